// File: doc/BRIEF.md
# MASH 2-1 Bitstream CIC Decimator

This block is the digital back end of a column-shared sigma-delta converter. Each input beat carries the two single-bit decisions of a cascaded modulator: a second-order first stage and a first-order second stage. A noise-cancellation network merges the two bits into one small signed value. In that value the first stage's quantization error is removed and the residual noise is shaped to third order.

The merged stream feeds a fourth-order cascaded integrator-comb decimator that uses no multipliers. Its integrators run at the input beat rate and wrap in two's complement. Its combs run once per output sample and shed low-order bits stage by stage, so each register is only as wide as it needs to be. The decimation ratio is a plain control input. One 16-bit sample leaves for every ratio accepted beats.

Both data edges are valid/ready streams. The block holds a single output sample. While that sample is offered and not taken, the input is refused (in_ready low). An input beat is therefore accepted exactly when in_valid is high and either the output slot is empty or out_ready is high in the same cycle. A produced sample stays on out_data, unchanged, until out_valid and out_ready are both high.

Top module: `mash_cic_decimator`

## Requirements
- R1: Bit value 1 maps to +1 and bit value 0 maps to -1. For accepted beat n the merged value is c[n] = a[n-1] + b[n] - 2·b[n-1] + b[n-2], where a is the first-stage bit and b is the second-stage bit. History terms count as 0 until enough beats have been accepted since reset, and c always lies in [-5, 5].
- R2: Four integrators are registered in cascade, each 36 bits wide with wrap-around arithmetic. On each accepted beat, stage 0 adds c and stage k adds the value that stage k-1 held before that beat.
- R3: Beats are counted from reset, and every dec_ratio-th accepted beat produces one output sample. That sample is taken from the last integrator's value just before that beat's update. out_valid rises only in the cycle after an accepted beat.
- R4: Each of the four comb stages arithmetic-shifts its input right by 5 bits. It then truncates the result to 31, 26, 21 and 16 bits respectively (stage 0 first) and subtracts its own previous shifted value at that width, with wrap-around. The last stage's result is out_data, in two's complement.
- R5: A constant input of a = b = 1 (c = 1) at ratio 256 gives settled outputs within ±3 of 4096.
- R6: While out_valid is high and out_ready is low, in_ready is low and out_valid, out_data and out_settled hold their values into the next cycle.
- R7: Cycles without an accepted beat change no filter state. They change neither the output stream nor the beat count toward the next output.
- R8: Synchronous active-high reset clears the combiner history, the integrators, the comb delays, the beat counter and the output slot. After reset out_valid is 0 and in_ready is 1.
- R9: out_settled is 0 on the first four samples after reset and 1 on every later sample.
- R10: dec_ratio may be any value from 1 to 256 and is changed only while reset is asserted. The beat counter stays below dec_ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_ratio | input | 9 | Decimation ratio, 1 to 256 |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be accepted |
| in_bit1 | input | 1 | First-stage modulator bit |
| in_bit2 | input | 1 | Second-stage modulator bit |
| out_valid | output | 1 | Output sample offered |
| out_ready | input | 1 | Consumer takes the sample |
| out_data | output | 16 | Decimated sample, two's complement |
| out_settled | output | 1 | Sample comes after the filter has filled |

## Verification
A wrong combiner tap or sign shows up in the very next output sample. The error is amplified by the integrator gain, so the sample differs from the reference by many codes, and this happens within one decimation period of the first accepted beat. A wrong integrator or comb width, or a slip in the beat counter, corrupts each later sample in turn or shifts the output cadence by whole beats, which the bench sees on the first sample after the fault. A handshake fault appears at once as a changed or lost sample while the consumer stalls.

// File: rtl/mash_cic_pkg.sv
package mash_cic_pkg;
  localparam int CIN_W = 4;
  typedef logic signed [CIN_W-1:0] merged_t;

  function automatic int prune_cum(input int total, input int k, input int n);
    return (total * k) / n;
  endfunction
endpackage

// File: rtl/mash_combiner.sv
module mash_combiner
  import mash_cic_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    en,
  input  logic    b1,
  input  logic    b2,
  output merged_t c
);
  logic signed [1:0] v1, v2, a_d, b_d, b_dd;
  merged_t e_a, e_b, e_bd, e_bdd;

  assign v1 = b1 ? 2'sb01 : 2'sb11;
  assign v2 = b2 ? 2'sb01 : 2'sb11;

  assign e_a   = {{(CIN_W-2){a_d[1]}}, a_d};
  assign e_b   = {{(CIN_W-2){v2[1]}}, v2};
  assign e_bd  = {{(CIN_W-2){b_d[1]}}, b_d};
  assign e_bdd = {{(CIN_W-2){b_dd[1]}}, b_dd};
  assign c     = e_a + e_b - (e_bd <<< 1) + e_bdd;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_d  <= '0;
      b_d  <= '0;
      b_dd <= '0;
    end else if (en) begin
      a_d  <= v1;
      b_dd <= b_d;
      b_d  <= v2;
    end
  end

  // R1: merged value bounded
  a_r1_range: assert property (@(posedge clk) disable iff (rst)
    (c >= -5) && (c <= 5));
endmodule

// File: rtl/cic_integrators.sv
module cic_integrators
  import mash_cic_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 36
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  merged_t             c,
  output logic signed [W-1:0] acc_out
);
  logic signed [W-1:0] acc [N];

  for (genvar g = 0; g < N; g++) begin : g_int
    always_ff @(posedge clk) begin
      if (rst) acc[g] <= '0;
      else if (en) begin
        if (g == 0) acc[g] <= acc[g] + W'(c);
        else        acc[g] <= acc[g] + acc[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign acc_out = acc[N-1];

  // R7: no accepted beat, no integrator movement
  a_r7_int_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc_out));
endmodule

// File: rtl/cic_combs.sv
module cic_combs
  import mash_cic_pkg::*;
#(
  parameter int N     = 4,
  parameter int W     = 36,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [W-1:0]     x,
  output logic signed [OUT_W-1:0] y
);
  localparam int TOT = W - OUT_W;

  logic signed [W-1:0] chain [N+1];
  assign chain[0] = x;

  for (genvar g = 0; g < N; g++) begin : g_comb
    localparam int LO   = prune_cum(TOT, g, N);
    localparam int HI   = prune_cum(TOT, g + 1, N);
    localparam int DROP = HI - LO;
    localparam int WK   = W - HI;
    logic signed [WK-1:0] d, dly, diff;

    assign d    = WK'(chain[g] >>> DROP);
    assign diff = d - dly;
    assign chain[g+1] = W'(diff);

    always_ff @(posedge clk) begin
      if (rst)     dly <= '0;
      else if (en) dly <= d;
    end

    // R4: comb delay only moves on a decimation instant
    a_r4_dly_hold: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(dly));
  end

  assign y = OUT_W'(chain[N]);
endmodule

// File: rtl/mash_cic_decimator.sv
module mash_cic_decimator
  import mash_cic_pkg::*;
#(
  parameter int N_STAGES  = 4,
  parameter int RMAX_LOG2 = 8,
  parameter int OUT_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [RMAX_LOG2:0]   dec_ratio,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_bit1,
  input  logic                 in_bit2,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [OUT_W-1:0]     out_data,
  output logic                 out_settled
);
  localparam int W_FULL  = CIN_W + N_STAGES * RMAX_LOG2;
  localparam int RATIO_W = RMAX_LOG2 + 1;
  localparam int SC_W    = $clog2(N_STAGES + 1);

  logic                     beat, dump;
  merged_t                  cval;
  logic signed [W_FULL-1:0] last_int;
  logic signed [OUT_W-1:0]  yout;
  logic [RATIO_W-1:0]       dec_cnt;
  logic [SC_W-1:0]          settle_cnt;

  assign in_ready = !out_valid || out_ready;
  assign beat     = in_valid && in_ready;
  assign dump     = beat && ((dec_cnt + RATIO_W'(1)) == dec_ratio);

  mash_combiner u_merge (
    .clk(clk), .rst(rst), .en(beat), .b1(in_bit1), .b2(in_bit2), .c(cval)
  );

  cic_integrators #(.N(N_STAGES), .W(W_FULL)) u_int (
    .clk(clk), .rst(rst), .en(beat), .c(cval), .acc_out(last_int)
  );

  cic_combs #(.N(N_STAGES), .W(W_FULL), .OUT_W(OUT_W)) u_comb (
    .clk(clk), .rst(rst), .en(dump), .x(last_int), .y(yout)
  );

  always_ff @(posedge clk) begin
    if (rst) dec_cnt <= '0;
    else if (beat) dec_cnt <= dump ? '0 : dec_cnt + RATIO_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_settled <= 1'b0;
      settle_cnt  <= '0;
    end else if (dump) begin
      out_valid   <= 1'b1;
      out_data    <= yout;
      out_settled <= (settle_cnt == SC_W'(N_STAGES));
      if (settle_cnt != SC_W'(N_STAGES)) settle_cnt <= settle_cnt + SC_W'(1);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R3: a new sample only follows an accepted beat
  a_r3_rise_after_beat: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(beat));
  // R6: stalled sample is held
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_settled)));
  // R9: settled flag never drops outside reset
  a_r9_monotonic: assert property (@(posedge clk) disable iff (rst)
    !$fell(out_settled));
  // R10: counter stays inside the ratio
  a_r10_cnt_range: assert property (@(posedge clk) disable iff (rst)
    dec_cnt < dec_ratio);
endmodule

// File: tb/tb_mash_cic_decimator.sv
module tb_mash_cic_decimator;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] dec_ratio = 9'd16;
  logic       in_valid = 1'b0, in_bit1 = 1'b0, in_bit2 = 1'b0, out_ready = 1'b0;
  logic       in_ready, out_valid, out_settled;
  logic [15:0] out_data;

  int checks = 0, errors = 0, cycles = 0;

  longint mi [4];
  longint md [4];
  int  y1d, y2d, y2dd, cnt, ratio, nout;
  bit  exp_valid, exp_set;
  longint exp_data;
  bit  prev_stall;
  logic [15:0] prev_data;

  mash_cic_decimator dut (
    .clk(clk), .rst(rst), .dec_ratio(dec_ratio), .in_valid(in_valid),
    .in_ready(in_ready), .in_bit1(in_bit1), .in_bit2(in_bit2),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_settled(out_settled)
  );

  always #5 clk = ~clk;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, cycles=%0d expected below 150000", cycles);
      finish_run();
    end
  end

  function automatic longint wrapw(input longint v, input int w);
    return (v <<< (64 - w)) >>> (64 - w);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 4; k++) begin mi[k] = 0; md[k] = 0; end
    y1d = 0; y2d = 0; y2dd = 0; cnt = 0; nout = 0;
    exp_valid = 0; exp_set = 0; exp_data = 0; prev_stall = 0;
  endtask

  // R1, R2, R3, R4, R9 reference
  task automatic model_beat(input bit b1, input bit b2);
    int v1, v2;
    longint c, x, d, y;
    v1 = b1 ? 1 : -1;
    v2 = b2 ? 1 : -1;
    c  = y1d + v2 - 2 * y2d + y2dd;
    if (cnt + 1 == ratio) begin
      x = mi[3];
      for (int k = 0; k < 4; k++) begin
        d = wrapw(x >>> 5, 36 - 5 * (k + 1));
        y = wrapw(d - md[k], 36 - 5 * (k + 1));
        md[k] = d;
        x = y;
      end
      exp_valid = 1; exp_data = x; exp_set = (nout >= 4);
      nout++;
      cnt = 0;
    end else cnt++;
    for (int k = 3; k > 0; k--) mi[k] = wrapw(mi[k] + mi[k-1], 36);
    mi[0] = wrapw(mi[0] + c, 36);
    y1d = v1; y2dd = y2d; y2d = v2;
  endtask

  task automatic do_reset(input int r);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; dec_ratio = 9'(r);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    ratio = r;
    model_reset();
    #1;
    check(out_valid == 1'b0, "R8 out_valid after reset", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R8 in_ready after reset", longint'(in_ready), 1);
  endtask

  // mode 0: random, 1: DC all ones full flow, 2: idle input
  task automatic run(input int n, input int mode, input int p_in, input int p_rdy);
    bit acc_in, acc_out;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mode == 1) begin
        in_valid = 1; in_bit1 = 1; in_bit2 = 1; out_ready = 1;
      end else begin
        in_valid  = (mode == 2) ? 1'b0 : (($urandom % 100) < p_in);
        in_bit1   = 1'($urandom);
        in_bit2   = 1'($urandom);
        out_ready = (($urandom % 100) < p_rdy);
      end
      #1;
      if (prev_stall)
        check(out_valid && out_data == prev_data, "R6 stalled sample held",
              longint'(out_data), longint'(prev_data));
      if (out_valid != exp_valid)
        check(0, (mode == 2) ? "R7 output during idle" : "R3 output cadence",
              longint'(out_valid), longint'(exp_valid));
      if (out_valid && !out_ready)
        check(!in_ready, "R6 in_ready low while stalled", longint'(in_ready), 0);
      acc_out = out_valid && out_ready;
      acc_in  = in_valid && in_ready;
      if (acc_out && exp_valid) begin
        check(longint'($signed(out_data)) == exp_data,
              (ratio == 1) ? "R10 sample at ratio 1" : "R4 sample value (R1 R2 R3 R7)",
              longint'($signed(out_data)), exp_data);
        check(out_settled == exp_set, "R9 settled flag", longint'(out_settled), longint'(exp_set));
        if (mode == 1 && exp_set)
          check(($signed(out_data) >= 4093) && ($signed(out_data) <= 4099),
                "R5 DC level", longint'($signed(out_data)), 4096);
        exp_valid = 0;
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (acc_in) model_beat(in_bit1, in_bit2);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    do_reset(16);
    run(1500, 0, 70, 60);
    do_reset(256);
    run(3000, 1, 100, 100);
    do_reset(256);
    run(4000, 0, 80, 50);
    do_reset(1);
    run(300, 0, 70, 70);
    do_reset(3);
    run(100, 0, 90, 90);
    run(50, 2, 0, 100);
    run(100, 0, 90, 30);
    do_reset(7);
    run(40, 2, 0, 100);
    run(400, 0, 60, 80);
    finish_run();
  end
endmodule